// File: doc/BRIEF.md
# Power Enable and Fast-Off Sequencer

This block is the digital sequencing core of a two-port power path. Three enable inputs are combined into a single request for the system power switch. When that request stays low long enough, the block reports a low-power shutdown state. Each of the two port channels has an on-request that must stay valid for a startup delay before the channel's gate enable is raised. A shared fast-off input removes both channel enables at once. After fast-off is released, both channels are held off for a long recovery delay.

The block also drives the enable of an ORing switch from two digital current-sense samples. The enable turns on when the mean of the two samples rises above a programmable threshold. It turns off when the mean falls below half of that threshold, and it holds its state in the band between the two levels.

Every delay is counted in microsecond ticks from a prescaler, so each delay depends only on the clock rate and on the parameters. The downstream fault timers and gate drivers take the channel enables directly.

Top module: `pwr_seq_ctl`

## Requirements
- R1: `sys_gate_o` is 1 exactly when (`en_x_i` OR `en_y_i`) AND `en_z_i` AND `sup_ok_i`. It follows a change on these inputs 3 clock cycles after the change.
- R2: `shdn_o` rises only after the enable combination (`en_x_i` OR `en_y_i`) AND `en_z_i` has been continuously low for `SHDN_US` ticks. A shorter low interval leaves it at 0. It falls 3 cycles after the combination returns high, and it is never 1 while `sys_gate_o` is 1.
- R3: While reset is applied, and directly after reset, every output is 0.
- R4: Channel i (bit i of `on_req_i` and `ch_en_o`, i = 0 or 1) turns on once its request, together with `sup_ok_i`, has stayed high for `ONDLY_US` ticks. The two channels are timed independently.
- R5: A channel enable drops 3 cycles after its request goes low or after `sup_ok_i` goes low. When the request or the supply returns, the full `ONDLY_US` delay runs again.
- R6: `foff_i` high clears both bits of `ch_en_o` 3 cycles after it rises, whatever the requests are.
- R7: After `foff_i` falls, neither channel turns on until `foff_i` has stayed low for `RECOV_US` ticks. A new fast-off pulse during that wait restarts the delay from zero.
- R8: `or_en_o` starts at 0. It rises 1 cycle after `sense_a_i + sense_b_i` (computed without overflow) becomes strictly greater than 2 x `or_thr_i`, which means the mean exceeds the threshold.
- R9: `or_en_o` falls 1 cycle after `sense_a_i + sense_b_i` becomes strictly less than `or_thr_i`, which means the mean is below half the threshold. Between the two levels it keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_x_i | input | 1 | First system-power enable (ORed with `en_y_i`) |
| en_y_i | input | 1 | Second system-power enable (ORed with `en_x_i`) |
| en_z_i | input | 1 | Qualifying enable, ANDed with the OR of the other two |
| sup_ok_i | input | 1 | Shared supply is above its lockout level |
| foff_i | input | 1 | Fast-off request for both channels |
| on_req_i | input | NUM_CH | Per-channel on-request, bit 0 = channel A |
| sense_a_i | input | SENSE_W | Channel A current-sense sample, unsigned |
| sense_b_i | input | SENSE_W | Channel B current-sense sample, unsigned |
| or_thr_i | input | SENSE_W | ORing threshold on the mean of the samples |
| sys_gate_o | output | 1 | System power switch enable |
| shdn_o | output | 1 | Low-power shutdown state |
| ch_en_o | output | NUM_CH | Per-channel gate enable |
| or_en_o | output | 1 | ORing switch enable |

## Verification
The control inputs pass through a two-stage synchronizer and then an output register. For that reason, every level-driven result (the system gate, a channel dropping, fast-off, and leaving shutdown) is due exactly 3 cycles after the input changes. The ORing enable is due 1 cycle after a sense change. Each of these results is checked one cycle early for its old value and then on its due cycle for its new value. The tick-counted delays (shutdown entry, channel startup and fast-off recovery) depend on the prescaler phase, which can shift them by up to one tick. Each of them is therefore checked at two points: the value must still be unchanged at (N-1) ticks plus 2 cycles, and the new value must be present at N ticks plus 4 cycles. The scoreboard keys every expected value to the absolute cycle on which it is due and compares it at the falling edge of that cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int unsigned NUM_CH = 2;

  // Counter width needed to hold values 0..limit.
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/pwr_seq_tick.sv
module pwr_seq_tick import pwr_seq_pkg::*; #(
  parameter int unsigned DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned LAST = DIV - 1;
  localparam int unsigned CW   = cnt_bits(LAST);
  localparam logic [CW-1:0] LAST_V = CW'(LAST);

  logic [CW-1:0] div_q;
  logic [CW-1:0] div_nx;
  logic          wrap;

  assign wrap = (div_q == LAST_V);

  always_comb begin
    div_nx = wrap ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_nx;
  end

  assign tick_o = wrap;
endmodule

// File: rtl/pwr_seq_hold.sv
// Qualification timer: done once cond_i has stayed high for LIMIT ticks.
module pwr_seq_hold import pwr_seq_pkg::*; #(
  parameter int unsigned LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic cond_i,
  output logic done_o
);
  localparam int unsigned CW = cnt_bits(LIMIT);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic          full;

  assign full = (cnt_q == LIM_V);

  always_comb begin
    cnt_nx = cnt_q;
    if (!cond_i)              cnt_nx = '0;
    else if (tick_i && !full) cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign done_o = cond_i && full;
endmodule

// File: rtl/pwr_seq_oring.sv
// ORing enable: compares sums against doubled thresholds so the mean
// keeps its half-bit of precision.
module pwr_seq_oring #(
  parameter int unsigned SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sense_a_i,
  input  logic [SW-1:0] sense_b_i,
  input  logic [SW-1:0] thr_i,
  output logic          or_en_o
);
  logic [SW:0] sum;
  logic [SW:0] on_lvl;
  logic [SW:0] off_lvl;
  logic        en_q;
  logic        en_nx;

  assign sum     = {1'b0, sense_a_i} + {1'b0, sense_b_i};
  assign on_lvl  = {thr_i, 1'b0};
  assign off_lvl = {1'b0, thr_i};

  always_comb begin
    en_nx = en_q;
    if (!en_q && (sum > on_lvl))      en_nx = 1'b1;
    else if (en_q && (sum < off_lvl)) en_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_nx;
  end

  assign or_en_o = en_q;
endmodule

// File: rtl/pwr_seq_ctl.sv
module pwr_seq_ctl import pwr_seq_pkg::*; #(
  parameter int unsigned CLK_PER_US = 250,
  parameter int unsigned SHDN_US    = 50,
  parameter int unsigned RECOV_US   = 1000000,
  parameter int unsigned ONDLY_US   = 2000,
  parameter int unsigned SENSE_W    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_x_i,
  input  logic               en_y_i,
  input  logic               en_z_i,
  input  logic               sup_ok_i,
  input  logic               foff_i,
  input  logic [NUM_CH-1:0]  on_req_i,
  input  logic [SENSE_W-1:0] sense_a_i,
  input  logic [SENSE_W-1:0] sense_b_i,
  input  logic [SENSE_W-1:0] or_thr_i,
  output logic               sys_gate_o,
  output logic               shdn_o,
  output logic [NUM_CH-1:0]  ch_en_o,
  output logic               or_en_o
);
  localparam int unsigned SYW   = NUM_CH + 5;
  localparam int unsigned I_FOF = NUM_CH;
  localparam int unsigned I_SUP = NUM_CH + 1;
  localparam int unsigned I_Z   = NUM_CH + 2;
  localparam int unsigned I_Y   = NUM_CH + 3;
  localparam int unsigned I_X   = NUM_CH + 4;

  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // Input synchronization
  logic [SYW-1:0] raw_in;
  logic [SYW-1:0] syn;

  assign raw_in = {en_x_i, en_y_i, en_z_i, sup_ok_i, foff_i, on_req_i};

  pwr_seq_sync #(.W(SYW)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (raw_in),
    .q_o   (syn)
  );

  logic en_comb;
  logic sup_s;
  logic foff_s;

  assign en_comb = (syn[I_X] | syn[I_Y]) & syn[I_Z];
  assign sup_s   = syn[I_SUP];
  assign foff_s  = syn[I_FOF];

  // Microsecond tick
  logic tick;

  pwr_seq_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (tick)
  );

  // Shutdown qualification
  logic shdn_done;

  pwr_seq_hold #(.LIMIT(SHDN_US)) u_shdn (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_i (tick),
    .cond_i (!en_comb),
    .done_o (shdn_done)
  );

  // Fast-off recovery
  logic rec_done;
  logic armed_q;
  logic armed_nx;
  logic foff_hold;

  pwr_seq_hold #(.LIMIT(RECOV_US)) u_recov (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_i (tick),
    .cond_i (!foff_s),
    .done_o (rec_done)
  );

  assign foff_hold = armed_q & ~rec_done;

  always_comb begin
    armed_nx = armed_q;
    if (foff_s)        armed_nx = 1'b1;
    else if (rec_done) armed_nx = 1'b0;
  end

  // Per-channel startup delay
  logic [NUM_CH-1:0] ch_ready;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    pwr_seq_hold #(.LIMIT(ONDLY_US)) u_ondly (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .tick_i (tick),
      .cond_i (syn[gi] & sup_s),
      .done_o (ch_ready[gi])
    );
  end

  // Output registers
  logic              gate_q, gate_nx;
  logic              shdn_q, shdn_nx;
  logic [NUM_CH-1:0] chen_q, chen_nx;

  always_comb begin
    gate_nx = en_comb & sup_s;
    shdn_nx = shdn_done;
    chen_nx = ch_ready & {NUM_CH{~foff_s & ~foff_hold}};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      gate_q  <= 1'b0;
      shdn_q  <= 1'b0;
      chen_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      gate_q  <= gate_nx;
      shdn_q  <= shdn_nx;
      chen_q  <= chen_nx;
      armed_q <= armed_nx;
    end
  end

  pwr_seq_oring #(.SW(SENSE_W)) u_oring (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sense_a_i (sense_a_i),
    .sense_b_i (sense_b_i),
    .thr_i     (or_thr_i),
    .or_en_o   (or_en_o)
  );

  assign sys_gate_o = gate_q;
  assign shdn_o     = shdn_q;
  assign ch_en_o    = chen_q;
endmodule

// File: rtl/pwr_seq_ctl_chk.sv
module pwr_seq_ctl_chk import pwr_seq_pkg::*; #(
  parameter int unsigned SENSE_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en_x_i,
  input logic               en_y_i,
  input logic               en_z_i,
  input logic               sup_ok_i,
  input logic               foff_i,
  input logic [NUM_CH-1:0]  on_req_i,
  input logic [SENSE_W-1:0] sense_a_i,
  input logic [SENSE_W-1:0] sense_b_i,
  input logic [SENSE_W-1:0] or_thr_i,
  input logic               sys_gate_o,
  input logic               shdn_o,
  input logic [NUM_CH-1:0]  ch_en_o,
  input logic               or_en_o
);
  logic [SENSE_W:0] sum_w;
  logic [SENSE_W:0] on_w;
  logic [SENSE_W:0] off_w;

  assign sum_w = {1'b0, sense_a_i} + {1'b0, sense_b_i};
  assign on_w  = {or_thr_i, 1'b0};
  assign off_w = {1'b0, or_thr_i};

  p_gate_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_gate_o) |-> $past(en_z_i, 3) && $past(sup_ok_i, 3) &&
                          ($past(en_x_i, 3) || $past(en_y_i, 3)));

  p_shdn_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_o |-> !sys_gate_o);

  p_supply_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_ok_i && !$past(sup_ok_i) && !$past(sup_ok_i, 2)) |=>
      (ch_en_o == '0) && !sys_gate_o);

  p_fast_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (foff_i && $past(foff_i) && $past(foff_i, 2)) |=> (ch_en_o == '0));

  p_or_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(or_en_o) |-> ($past(sum_w) > $past(on_w)));

  p_or_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(or_en_o) |-> ($past(sum_w) < $past(off_w)));

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chk
    p_chan_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_en_o[gi]) |-> $past(on_req_i[gi], 3) && $past(sup_ok_i, 3));

    p_chan_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_en_o[gi]) |-> !$past(foff_i, 3));
  end
endmodule

bind pwr_seq_ctl pwr_seq_ctl_chk #(.SENSE_W(SENSE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_x_i     (en_x_i),
  .en_y_i     (en_y_i),
  .en_z_i     (en_z_i),
  .sup_ok_i   (sup_ok_i),
  .foff_i     (foff_i),
  .on_req_i   (on_req_i),
  .sense_a_i  (sense_a_i),
  .sense_b_i  (sense_b_i),
  .or_thr_i   (or_thr_i),
  .sys_gate_o (sys_gate_o),
  .shdn_o     (shdn_o),
  .ch_en_o    (ch_en_o),
  .or_en_o    (or_en_o)
);

// File: tb/pwr_seq_ctl_bench.sv
`timescale 1ns/1ps
module pwr_seq_ctl_bench;
  localparam int unsigned P  = 4;
  localparam int unsigned SD = 5;
  localparam int unsigned RC = 50;
  localparam int unsigned OD = 20;
  localparam int unsigned SW = 10;

  // Output vector bit masks: {sys_gate, shdn, ch1, ch0, or_en}
  localparam logic [4:0] M_SG = 5'b10000;
  localparam logic [4:0] M_SD = 5'b01000;
  localparam logic [4:0] M_C1 = 5'b00100;
  localparam logic [4:0] M_C0 = 5'b00010;
  localparam logic [4:0] M_OR = 5'b00001;
  localparam logic [4:0] M_CH = 5'b00110;

  logic          clk;
  logic          rst_n;
  logic          en_x, en_y, en_z, sup_ok, foff;
  logic [1:0]    on_req;
  logic [SW-1:0] sense_a, sense_b, thr;
  logic          sys_gate, shdn, or_en;
  logic [1:0]    ch_en;

  pwr_seq_ctl #(
    .CLK_PER_US(P), .SHDN_US(SD), .RECOV_US(RC), .ONDLY_US(OD), .SENSE_W(SW)
  ) u_pwr_seq_ctl (
    .clk(clk), .rst_n(rst_n), .en_x_i(en_x), .en_y_i(en_y), .en_z_i(en_z),
    .sup_ok_i(sup_ok), .foff_i(foff), .on_req_i(on_req),
    .sense_a_i(sense_a), .sense_b_i(sense_b), .or_thr_i(thr),
    .sys_gate_o(sys_gate), .shdn_o(shdn), .ch_en_o(ch_en), .or_en_o(or_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;
  bit fin   = 1'b0;

  // Scoreboard queues
  int         due_q[$];
  logic [4:0] mask_q[$];
  logic [4:0] val_q[$];
  string      tag_q[$];

  task automatic expect_at(input int dly, input logic [4:0] m,
                           input logic [4:0] v, input string tag);
    due_q.push_back(cyc + dly);
    mask_q.push_back(m);
    val_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [4:0] obs;
  assign obs = {sys_gate, shdn, ch_en[1], ch_en[0], or_en};

  always @(negedge clk) begin
    for (int i = due_q.size() - 1; i >= 0; i--) begin
      if (due_q[i] == cyc) begin
        n_cmp++;
        if (((obs ^ val_q[i]) & mask_q[i]) != 5'b0) begin
          n_bad++;
          $display("FAIL %s: got %b expected %b (mask %b) at cycle %0d",
                   tag_q[i], obs & mask_q[i], val_q[i] & mask_q[i], mask_q[i], cyc);
        end
        due_q.delete(i); mask_q.delete(i); val_q.delete(i); tag_q.delete(i);
      end
    end
  end

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): got hung run expected completion");
      summary();
      $finish;
    end
  end

  localparam int OD_EARLY = 2 + (OD - 1) * P;
  localparam int OD_LATE  = OD * P + 4;
  localparam int RC_EARLY = 2 + (RC - 1) * P;
  localparam int RC_LATE  = RC * P + 4;
  localparam int SD_EARLY = 2 + (SD - 1) * P;
  localparam int SD_LATE  = SD * P + 4;

  initial begin
    rst_n = 1'b0; en_x = 0; en_y = 0; en_z = 0; sup_ok = 0; foff = 0;
    on_req = 2'b00; sense_a = '0; sense_b = '0; thr = 10'd100;
    step(3);
    rst_n = 1'b1;
    expect_at(1, 5'b11111, 5'b00000, "R3 reset state");
    expect_at(SD_EARLY, 5'b11111, 5'b00000, "R3 outputs low after reset");
    expect_at(SD_LATE + 3, M_SD | M_SG, M_SD, "R2 idle shutdown");
    step(SD_LATE + 4);

    // R1 truth table
    sup_ok = 1; en_x = 1; en_z = 1;
    expect_at(2, M_SG, 5'b0, "R1 old value before latency");
    expect_at(3, M_SG | M_SD, M_SG, "R1 x&z on, R2 shutdown cleared");
    step(4);
    en_z = 0;
    expect_at(3, M_SG, 5'b0, "R1 z low gates off");
    step(4);
    en_z = 1; en_x = 0; en_y = 1;
    expect_at(3, M_SG | M_SD, M_SG, "R1 y&z on, R2 short low no shutdown");
    step(4);
    sup_ok = 0;
    expect_at(3, M_SG, 5'b0, "R1 supply lockout");
    step(4);
    sup_ok = 1;
    expect_at(3, M_SG, M_SG, "R1 supply back");
    step(4);

    // R2 persistence
    en_y = 0;
    expect_at(SD_EARLY, M_SD, 5'b0, "R2 not before delay");
    expect_at(SD_LATE, M_SD | M_SG, M_SD, "R2 shutdown entered");
    step(SD_LATE + 1);
    en_y = 1;
    expect_at(2, M_SD, M_SD, "R2 exit old value");
    expect_at(3, M_SD | M_SG, M_SG, "R2 exit shutdown");
    step(4);
    en_y = 0;
    step(12);
    en_y = 1;
    expect_at(1, M_SD, 5'b0, "R2 short low ignored");
    expect_at(15, M_SD | M_SG, M_SG, "R2 short low ignored later");
    step(16);

    // R4 channel delays
    on_req = 2'b01;
    expect_at(OD_EARLY, M_CH, 5'b0, "R4 ch0 not early");
    expect_at(OD_LATE, M_CH, M_C0, "R4 ch0 on, ch1 independent");
    step(OD_LATE + 1);
    on_req = 2'b11;
    expect_at(OD_EARLY, M_CH, M_C0, "R4 ch1 not early");
    expect_at(OD_LATE, M_CH, M_CH, "R4 ch1 on");
    step(OD_LATE + 1);

    // R5 drops
    on_req = 2'b10;
    expect_at(2, M_C0, M_C0, "R5 old value before latency");
    expect_at(3, M_CH, M_C1, "R5 ch0 request drop");
    step(4);
    on_req = 2'b11;
    expect_at(OD_LATE, M_CH, M_CH, "R5 ch0 back after delay");
    step(OD_LATE + 1);
    sup_ok = 0;
    expect_at(3, M_CH | M_SG, 5'b0, "R5 supply low drops both");
    step(4);
    sup_ok = 1;
    expect_at(OD_EARLY, M_CH, 5'b0, "R5 re-delay after supply");
    expect_at(OD_LATE, M_CH, M_CH, "R5 on after supply re-delay");
    step(OD_LATE + 1);

    // R6 fast-off, R7 recovery
    foff = 1;
    expect_at(2, M_CH, M_CH, "R6 old value before latency");
    expect_at(3, M_CH, 5'b0, "R6 fast-off kills both");
    expect_at(9, M_CH, 5'b0, "R6 held during fast-off");
    step(10);
    foff = 0;
    expect_at(RC_EARLY, M_CH, 5'b0, "R7 held off during recovery");
    expect_at(RC_LATE, M_CH, M_CH, "R7 recovery done");
    step(RC_LATE + 1);
    foff = 1;
    step(3);
    foff = 0;
    step(100);
    foff = 1;
    step(3);
    foff = 0;
    expect_at(RC_LATE - 106, M_CH, 5'b0, "R7 not on at first deadline");
    expect_at(RC_EARLY, M_CH, 5'b0, "R7 restarted delay");
    expect_at(RC_LATE, M_CH, M_CH, "R7 on after restarted delay");
    step(RC_LATE + 1);

    // R8 / R9 ORing with threshold 100
    sense_a = 10'd90;  sense_b = 10'd100;
    expect_at(1, M_OR, 5'b0, "R8 sum 190 stays off");
    step(3);
    sense_a = 10'd100; sense_b = 10'd100;
    expect_at(1, M_OR, 5'b0, "R8 sum equal to 200 stays off");
    step(3);
    sense_a = 10'd110; sense_b = 10'd100;
    expect_at(1, M_OR, M_OR, "R8 sum 210 turns on");
    step(3);
    sense_a = 10'd60;  sense_b = 10'd50;
    expect_at(1, M_OR, M_OR, "R9 in band holds on");
    step(3);
    sense_a = 10'd50;  sense_b = 10'd50;
    expect_at(1, M_OR, M_OR, "R9 at off level holds on");
    step(3);
    sense_a = 10'd50;  sense_b = 10'd49;
    expect_at(1, M_OR, 5'b0, "R9 below off level turns off");
    step(3);
    sense_a = 10'd60;  sense_b = 10'd60;
    expect_at(1, M_OR, 5'b0, "R9 in band holds off");
    step(3);
    sense_a = 10'd1023; sense_b = 10'd1023;
    expect_at(1, M_OR, M_OR, "R8 full scale no wrap");
    step(3);
    sense_a = 10'd0;   sense_b = 10'd0;
    expect_at(1, M_OR, 5'b0, "R9 zero turns off");
    step(5);

    while (due_q.size() != 0) step(1);
    fin = 1'b1;
    summary();
    $finish;
  end
endmodule